// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block computes single-error-correcting Hamming codes over the data stream of a NAND flash controller. Each byte moving through the controller's data register, toward the flash or from it, is presented on a transfer strobe. While the engine is accumulating, each such byte updates the parity of the current 256-byte chunk. A sector holds `NCHUNK` chunks, two by default for 512-byte sectors. A 2-bit mode field written by the controller selects one of four modes: clear, off, accumulate or read-out.

Software first writes clear, then off, then accumulate, and streams the sector. To fetch the codes it writes off and then read-out. Each data-register read then returns a code byte in place of flash data and raises no flash strobe. Software compares these codes with the stored ones and does the correction itself.

Each code is 3 bytes. Code byte 0 holds line parities for byte-address bits 0 to 3, and code byte 1 holds those for address bits 4 to 7. Code byte 2 holds the six column parities. All stored bits are inverted, so erased data gives 0xFF codes.

Top module: `nand_ecc_accum`

## Requirements
- R1: The mode field decodes as 2'b11 clear, 2'b00 off, 2'b01 accumulate and 2'b10 read-out. A value written with `mode_we` governs behaviour from the next clock cycle.
- R2: After the engine has spent at least one cycle in clear mode, every code byte reads as 0xFF. A sector of all-0xFF data also gives all-0xFF codes.
- R3: In accumulate mode, each `xfer_vld` byte at chunk offset a (0..255) with value d updates the code. Let p be the XOR of the bits of d. For each address bit k, line parity L(2k+1) toggles with p when a[k]=1, and L(2k) toggles with p when a[k]=0. Code byte 0 bit j = ~L(j) and code byte 1 bit j = ~L(8+j), for j = 0..7. Code byte 2 holds, from bit 7 down to bit 2, the inverted column parities over data bits {7,6,5,4}, {3,2,1,0}, {7,6,3,2}, {5,4,1,0}, {7,5,3,1} and {6,4,2,0}. Its bits 1:0 are always 1.
- R4: Bytes 0..255 of a sector update code 0 and bytes 256..511 update code 1.
- R5: Once NCHUNK*256 bytes have been accumulated, further transfer bytes are ignored until the next clear.
- R6: In off mode, transfer bytes change neither the codes nor the byte position. Accumulation resumes at the same position when accumulate mode is written again.
- R7: In read-out mode, successive reads return code 0 byte 1, code 0 byte 0, code 0 byte 2, then the same three bytes of code 1. After the last byte the sequence wraps to the start.
- R8: In read-out mode, `rd_data` is the current code byte and `flash_strobe` stays low. In every other mode, `rd_data` equals `flash_rd_data` and `flash_strobe` follows `rd_req`.
- R9: Clear mode also resets the byte position and the read-out pointer. The next sector therefore starts at code 0, and the next read-out starts at code 0 byte 1.
- R10: The synchronous active-low reset puts the engine in off mode with the codes, the byte position and the pointer cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_in | input | 2 | Mode value written on `mode_we` |
| xfer_vld | input | 1 | A byte passes through the data register this cycle |
| xfer_byte | input | 8 | The byte passing through |
| rd_req | input | 1 | Data-register read request |
| flash_rd_data | input | 8 | Data returned by the flash |
| rd_data | output | 8 | Data-register read value |
| flash_strobe | output | 1 | Flash read strobe request |

## Verification
The assertions take the mode encoding of R1 as complete and assume that `rd_req` and `xfer_vld` are single-cycle pulses. They also assume that the controller writes clear before each new sector, so the byte position starts at zero. The stimulus keeps to these rules: every sector begins with the clear, off, accumulate sequence, and every read and transfer is one cycle long. Random data fills the sectors. Directed cases cover erased data, a single set byte, an interruption in off mode, bytes beyond the sector end, pointer wrap, and a clear issued part-way through.

// File: rtl/nand_ecc_pkg.sv
// Package: shared types and parity helpers for the NAND Hamming ECC accumulator.
// Assumes 8-bit data and 256-byte chunks.
package nand_ecc_pkg;

    localparam int CHUNK_BYTES = 256;
    localparam int PAR_BITS    = 22;   // 16 line + 6 column parities

    typedef enum logic [1:0] {
        ECC_OFF   = 2'b00,
        ECC_ACC   = 2'b01,
        ECC_READ  = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    // Column parity contribution of one byte, bit 5 down to bit 0:
    // {7,6,5,4} {3,2,1,0} {7,6,3,2} {5,4,1,0} {7,5,3,1} {6,4,2,0}
    function automatic logic [5:0] col_par(input logic [7:0] d);
        col_par[5] = ^d[7:4];
        col_par[4] = ^d[3:0];
        col_par[3] = d[7] ^ d[6] ^ d[3] ^ d[2];
        col_par[2] = d[5] ^ d[4] ^ d[1] ^ d[0];
        col_par[1] = d[7] ^ d[5] ^ d[3] ^ d[1];
        col_par[0] = d[6] ^ d[4] ^ d[2] ^ d[0];
    endfunction

endpackage

// File: rtl/nand_ecc_chunk_par.sv
// Module: raw parity store of one 256-byte chunk.
// Holds 16 line parities in [15:0] and 6 column parities in [21:16], non-inverted.
// Assumes clr and upd are never meaningful together; clr wins.
module nand_ecc_chunk_par
    import nand_ecc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                upd,
    input  logic [AW-1:0]       addr,
    input  logic [7:0]          din,
    output logic [PAR_BITS-1:0] par
);

    localparam int LINE_BITS = 2 * AW;

    logic [PAR_BITS-1:0] par_q;
    logic [PAR_BITS-1:0] par_nxt;
    logic                byte_p;

    // Next parity value if the current byte is folded in.
    always_comb begin
        byte_p  = ^din;
        par_nxt = par_q;
        for (int k = 0; k < AW; k++) begin
            if (addr[k]) par_nxt[2*k+1] = par_q[2*k+1] ^ byte_p;
            else         par_nxt[2*k]   = par_q[2*k]   ^ byte_p;
        end
        par_nxt[PAR_BITS-1:LINE_BITS] = par_q[PAR_BITS-1:LINE_BITS] ^ col_par(din);
    end

    // Parity register: cleared by reset or clear mode, updated per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) par_q <= '0;
        else if (upd)      par_q <= par_nxt;
    end

    assign par = par_q;

endmodule

// File: rtl/nand_ecc_seq.sv
// Module: byte position and read-out pointer sequencing.
// Counts bytes within a chunk, steps the chunk index up to NCHUNK (sector full),
// and walks the read-out pointer through 3 bytes per chunk with wrap.
module nand_ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int NCHUNK = 2,
    parameter int AW     = 8,
    localparam int CIW   = $clog2(NCHUNK + 1),
    localparam int PW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ecc_mode_e      mode,
    input  logic           xfer_vld,
    input  logic           rd_req,
    output logic           acc_en,
    output logic [AW-1:0]  byte_cnt,
    output logic [CIW-1:0] chunk_idx,
    output logic [1:0]     ptr_sub,
    output logic [PW-1:0]  ptr_chunk
);

    localparam logic [CIW-1:0] FULL_IDX  = CIW'(NCHUNK);
    localparam logic [PW-1:0]  LAST_PTR  = PW'(NCHUNK - 1);
    localparam logic [AW-1:0]  LAST_BYTE = '1;

    logic clr;
    logic rd_step;

    assign clr     = (mode == ECC_CLEAR);
    assign acc_en  = (mode == ECC_ACC) && xfer_vld && (chunk_idx != FULL_IDX);
    assign rd_step = (mode == ECC_READ) && rd_req;

    // Byte position within the sector: offset and chunk index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            byte_cnt  <= '0;
            chunk_idx <= '0;
        end else if (acc_en) begin
            byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == LAST_BYTE) chunk_idx <= chunk_idx + 1'b1;
        end
    end

    // Read-out pointer: byte within code (0..2) and code index, wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_sub   <= 2'd0;
            ptr_chunk <= '0;
        end else if (rd_step) begin
            if (ptr_sub == 2'd2) begin
                ptr_sub   <= 2'd0;
                ptr_chunk <= (ptr_chunk == LAST_PTR) ? '0 : ptr_chunk + 1'b1;
            end else begin
                ptr_sub <= ptr_sub + 2'd1;
            end
        end
    end

endmodule

// File: rtl/nand_ecc_accum.sv
// Module: NAND Hamming ECC accumulator top.
// Holds the mode field, one parity store per chunk, the sequencer and the
// read-out mux. Codes are stored non-inverted and inverted on read-out.
// Assumes rd_req and xfer_vld are single-cycle per byte.
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int NCHUNK = 2,
    localparam int AW    = $clog2(CHUNK_BYTES),
    localparam int CIW   = $clog2(NCHUNK + 1),
    localparam int PW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_in,
    input  logic       xfer_vld,
    input  logic [7:0] xfer_byte,
    input  logic       rd_req,
    input  logic [7:0] flash_rd_data,
    output logic [7:0] rd_data,
    output logic       flash_strobe
);

    ecc_mode_e                  mode_q;
    logic                       acc_en;
    logic [AW-1:0]              byte_cnt;
    logic [CIW-1:0]             chunk_idx;
    logic [1:0]                 ptr_sub;
    logic [PW-1:0]              ptr_chunk;
    logic [PAR_BITS-1:0]        par [NCHUNK];
    logic [NCHUNK*PAR_BITS-1:0] par_all;
    logic [PAR_BITS-1:0]        sel_par;
    logic [7:0]                 code_byte;

    // Mode field register; reset leaves the engine off.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= ECC_OFF;
        else if (mode_we) mode_q <= ecc_mode_e'(mode_in);
    end

    nand_ecc_seq #(.NCHUNK(NCHUNK), .AW(AW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .xfer_vld  (xfer_vld),
        .rd_req    (rd_req),
        .acc_en    (acc_en),
        .byte_cnt  (byte_cnt),
        .chunk_idx (chunk_idx),
        .ptr_sub   (ptr_sub),
        .ptr_chunk (ptr_chunk)
    );

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        nand_ecc_chunk_par #(.AW(AW)) i_par (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_q == ECC_CLEAR),
            .upd   (acc_en && (chunk_idx == CIW'(g))),
            .addr  (byte_cnt),
            .din   (xfer_byte),
            .par   (par[g])
        );
        assign par_all[g*PAR_BITS +: PAR_BITS] = par[g];
    end

    // Read-out mux: order within a code is byte 1, byte 0, byte 2.
    always_comb begin
        sel_par = par[ptr_chunk];
        case (ptr_sub)
            2'd0:    code_byte = ~sel_par[15:8];
            2'd1:    code_byte = ~sel_par[7:0];
            default: code_byte = ~{sel_par[21:16], 2'b00};
        endcase
    end

    // Data-register read path: code bytes replace flash data in read-out mode.
    always_comb begin
        if (mode_q == ECC_READ) begin
            rd_data      = code_byte;
            flash_strobe = 1'b0;
        end else begin
            rd_data      = flash_rd_data;
            flash_strobe = rd_req;
        end
    end

endmodule

// File: rtl/nand_ecc_accum_chk.sv
// Checker: temporal properties of the ECC accumulator, bound to the top.
module nand_ecc_accum_chk
    import nand_ecc_pkg::*;
#(
    parameter int NCHUNK = 2,
    parameter int CIW    = 2,
    parameter int PW     = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input ecc_mode_e                  mode_q,
    input logic                       rd_req,
    input logic                       flash_strobe,
    input logic [7:0]                 byte_cnt,
    input logic [CIW-1:0]             chunk_idx,
    input logic [1:0]                 ptr_sub,
    input logic [PW-1:0]              ptr_chunk,
    input logic [NCHUNK*PAR_BITS-1:0] par_all
);

    // Clear mode empties codes, position and pointer on the next cycle.
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ECC_CLEAR) |=> (par_all == '0 && byte_cnt == '0 &&
                                    chunk_idx == '0 && ptr_sub == 2'd0 && ptr_chunk == '0));

    // Off mode freezes codes and byte position.
    p_off_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ECC_OFF) |=> ($stable(par_all) && $stable(byte_cnt) && $stable(chunk_idx)));

    // A full sector ignores further bytes.
    p_full_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_idx == CIW'(NCHUNK) && mode_q != ECC_CLEAR) |=> $stable(par_all));

    // Pointer stays in range.
    p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sub <= 2'd2) && (int'(ptr_chunk) < NCHUNK));

    // Pointer only moves on a read in read-out mode.
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != ECC_CLEAR && !(mode_q == ECC_READ && rd_req)) |=>
            ($stable(ptr_sub) && $stable(ptr_chunk)));

    // No flash strobe while code bytes are being read.
    p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ECC_READ && rd_req) |-> !flash_strobe);

    // Chunk index never passes the sector size.
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chunk_idx) <= NCHUNK);

endmodule

bind nand_ecc_accum nand_ecc_accum_chk #(.NCHUNK(NCHUNK), .CIW(CIW), .PW(PW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .rd_req       (rd_req),
    .flash_strobe (flash_strobe),
    .byte_cnt     (byte_cnt),
    .chunk_idx    (chunk_idx),
    .ptr_sub      (ptr_sub),
    .ptr_chunk    (ptr_chunk),
    .par_all      (par_all)
);

// File: tb/test_nand_ecc_accum.sv
`timescale 1ns/1ps
// Bench: random and directed sectors checked against a reference code model.
module test_nand_ecc_accum;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic       xfer_vld = 1'b0;
    logic [7:0] xfer_byte = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] flash_rd_data = 8'h00;
    logic [7:0] rd_data;
    logic       flash_strobe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    logic [7:0] mem [512];

    localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;

    always #2.5 clk = ~clk;

    nand_ecc_accum i_nand_ecc_accum (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .xfer_vld(xfer_vld), .xfer_byte(xfer_byte), .rd_req(rd_req),
        .flash_rd_data(flash_rd_data), .rd_data(rd_data), .flash_strobe(flash_strobe)
    );

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Reference code of the chunk starting at base: {byte2, byte1, byte0}.
    function automatic logic [23:0] ref_code(input int base);
        logic [15:0] lp = '0;
        logic [5:0]  cp = '0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d = mem[base + a];
            logic p = ^d;
            for (int k = 0; k < 8; k++)
                if (a[k]) lp[2*k+1] ^= p; else lp[2*k] ^= p;
            cp[5] ^= ^d[7:4];
            cp[4] ^= ^d[3:0];
            cp[3] ^= d[7] ^ d[6] ^ d[3] ^ d[2];
            cp[2] ^= d[5] ^ d[4] ^ d[1] ^ d[0];
            cp[1] ^= d[7] ^ d[5] ^ d[3] ^ d[1];
            cp[0] ^= d[6] ^ d[4] ^ d[2] ^ d[0];
        end
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_we = 1'b1; mode_in = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); xfer_vld = 1'b1; xfer_byte = b;
        @(negedge clk); xfer_vld = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d, output logic s);
        @(negedge clk); rd_req = 1'b1; flash_rd_data = 8'($urandom);
        #1 d = rd_data; s = flash_strobe;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic enable();
        set_mode(M_CLR); set_mode(M_OFF); set_mode(M_ACC);
    endtask

    task automatic send_range(input int lo, input int hi);
        for (int i = lo; i < hi; i++) send(mem[i]);
    endtask

    // Read 6 code bytes and compare with the reference order byte1, byte0, byte2.
    task automatic read_codes(input string req);
        logic [7:0] d; logic s;
        set_mode(M_OFF); set_mode(M_RD);
        for (int c = 0; c < 2; c++) begin
            logic [23:0] r = ref_code(c * 256);
            rd(d, s); check({req, " R7 byte1"}, d, r[15:8]);
            rd(d, s); check({req, " R7 byte0"}, d, r[7:0]);
            rd(d, s); check({req, " R7 byte2"}, d, r[23:16]);
            check({req, " R8 no strobe"}, {7'd0, s}, 8'd0);
        end
    endtask

    initial begin
        logic [7:0] d; logic s;
        logic [7:0] first [6];
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 / R8: reset leaves off mode, reads pass through to flash.
        @(negedge clk); rd_req = 1'b1; flash_rd_data = 8'h5a;
        #1 check("R10 R8 passthrough data", rd_data, 8'h5a);
        check("R10 R8 strobe follows", {7'd0, flash_strobe}, 8'd1);
        @(negedge clk); rd_req = 1'b0;
        set_mode(M_RD);
        for (int i = 0; i < 6; i++) begin
            rd(d, s); check("R10 cleared codes", d, 8'hff);
        end

        // R2: erased sector gives all-ones codes.
        for (int i = 0; i < 512; i++) mem[i] = 8'hff;
        enable(); send_range(0, 512); read_codes("R2 erased");

        // R1 / R8: accumulate mode still passes reads to flash.
        enable();
        @(negedge clk); rd_req = 1'b1; flash_rd_data = 8'hc3;
        #1 check("R1 R8 acc passthrough", rd_data, 8'hc3);
        check("R1 R8 acc strobe", {7'd0, flash_strobe}, 8'd1);
        @(negedge clk); rd_req = 1'b0;

        // R3: single set byte at offset 0x93 of chunk 0, all else zero.
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[8'h93] = 8'h01;
        enable(); send_range(0, 512); read_codes("R3 single byte");

        // R3 / R4: random sectors.
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
            enable(); send_range(0, 512); read_codes("R3 R4 random");
        end

        // R5: bytes after a full sector are ignored.
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        enable(); send_range(0, 512);
        for (int i = 0; i < 20; i++) send(8'($urandom));
        read_codes("R5 overrun");

        // R6: off mode interruption drops bytes and keeps the position.
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        enable(); send_range(0, 300);
        set_mode(M_OFF);
        for (int i = 0; i < 40; i++) send(8'($urandom));
        set_mode(M_ACC); send_range(300, 512);
        read_codes("R6 off freeze");

        // R7: pointer wraps after six reads.
        set_mode(M_CLR); set_mode(M_OFF); set_mode(M_RD);
        enable(); send_range(0, 512); set_mode(M_OFF); set_mode(M_RD);
        for (int i = 0; i < 6; i++) begin rd(d, s); first[i] = d; end
        for (int i = 0; i < 6; i++) begin rd(d, s); check("R7 wrap", d, first[i]); end

        // R9: clear part-way restarts position and pointer.
        set_mode(M_OFF); set_mode(M_RD);
        rd(d, s); rd(d, s);
        for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
        set_mode(M_ACC);
        for (int i = 0; i < 100; i++) send(8'($urandom));
        enable(); send_range(0, 512);
        read_codes("R9 clear restart");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule